// File: doc/BRIEF.md
# Baud Divisor Selection Engine

This block turns a reference clock rate and a requested serial line rate into the settings a bit-timing unit needs: a 10-bit prescaler and a packed 32-bit oversampling word. It first tries the plain sixteen-samples-per-bit scheme. If that prescaler would not fit in ten bits, it switches to a uniform count of 63 clocks per bit in all four oversampling fields and computes the prescaler again. The final prescaler is then clamped into its legal range.

Along with the settings, the block reports the slowest and fastest line rates the given reference clock can support. All divisions share one shift-subtract divider that produces one quotient bit per cycle. A computation starts on a one-cycle start pulse. The block latches its operands on that pulse and signals completion with a one-cycle done pulse. A start pulse that arrives while a computation is running is dropped.

Top module: `baud_div_sel`

## Requirements
- R1: After reset, before any computation, the outputs are prescaler 1, oversampling word 0, error 0, minimum 0, maximum 0, and done 0.
- R2: Each rounded quotient is (dividend + floor(divisor/2)) / divisor in integer arithmetic, so a remainder of exactly half rounds up.
- R3: The first attempt uses prescaler round(clk / (16 × baud)). If the result is at most 1023, it is the answer and the oversampling word is 0x00000000.
- R4: If the first attempt exceeds 1023, the prescaler becomes round(clk / (63 × baud)). The oversampling word then carries 63 in each of its four 8-bit fields (bits 7:0, 15:8, 23:16, 31:24), which gives 0x3F3F3F3F.
- R5: The reported prescaler is clamped: a result of 0 becomes 1, and a result above 1023 becomes 1023.
- R6: The minimum rate output equals ceil(clk / 64449), where 64449 = 1023 × 63. The maximum rate output equals floor(clk / 80).
- R7: A requested rate of zero gives prescaler 1, oversampling word 0 and error 1. Any nonzero rate gives error 0.
- R8: Done is high for exactly one cycle per accepted start. All result outputs change only in the cycle in which done is high, and they hold their values at all other times.
- R9: A start pulse received while a computation is in progress is ignored. It changes neither the results of the running computation nor the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; operands are sampled on it |
| clk_rate_i | input | 32 | Reference clock rate in Hz |
| baud_i | input | 32 | Requested line rate in bits per second |
| div_d_o | output | 10 | Prescaler, 1 to 1023 |
| osamp_o | output | 32 | Packed oversampling word, four 8-bit fields |
| err_o | output | 1 | Requested rate was zero |
| min_baud_o | output | 32 | Lowest supported line rate |
| max_baud_o | output | 32 | Highest supported line rate |
| done_o | output | 1 | One-cycle pulse when all outputs are valid |

## Verification
The checker makes no assumption about the operand values. It relies only on reset being asserted before the first clock, and it checks the done pulse width, the prescaler range, the two legal oversampling encodings, the zero-rate outcome and output stability against the done pulse for any input sequence. The stimulus changes operands and start on the falling edge and gives start as a single-cycle pulse. It changes operands mid-computation only in the deliberate test of a start that arrives while busy. Operand values run from zero up to the full 32-bit clock rate, so the widened divider path is exercised.

// File: rtl/baud_div_sel_pkg.sv
package baud_div_sel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MIN,
    ST_MAX,
    ST_D16,
    ST_D63,
    ST_FIN
  } sel_state_e;
endpackage

// File: rtl/baud_div_seq.sv
// Restoring divider, one quotient bit per cycle.
module baud_div_seq #(
  parameter int N = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic         done_o,
  output logic [N-1:0] quot_o
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [N:0]    rem_sh, rem_sub;
  logic          ge;

  always_comb begin
    rem_sh  = {rem_q, quo_q[N-1]};
    ge      = rem_sh >= {1'b0, dvs_q};
    rem_sub = rem_sh - {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= CW'(N);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? rem_sub[N-1:0] : rem_sh[N-1:0];
        quo_q <= {quo_q[N-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;
endmodule

// File: rtl/baud_op_mux.sv
// Builds dividend/divisor for each sequencer step.
module baud_op_mux
  import baud_div_sel_pkg::*;
#(
  parameter int CLK_W     = 32,
  parameter int N         = 48,
  parameter int D_MAX     = 1023,
  parameter int M_DEF     = 16,
  parameter int M_MAX     = 63,
  parameter int MAX_RATIO = 80
) (
  input  sel_state_e       state_i,
  input  logic [CLK_W-1:0] clk_rate_i,
  input  logic [CLK_W-1:0] baud_i,
  output logic [N-1:0]     dividend_o,
  output logic [N-1:0]     divisor_o
);
  localparam logic [N-1:0] MIN_DIV = N'(D_MAX * M_MAX);

  logic [N-1:0] clk_w, prod;

  always_comb begin
    clk_w = N'(clk_rate_i);
    prod  = (state_i == ST_D63) ? N'(baud_i) * N'(M_MAX) : N'(baud_i) * N'(M_DEF);
    unique case (state_i)
      ST_MIN: begin
        dividend_o = clk_w + MIN_DIV - N'(1);
        divisor_o  = MIN_DIV;
      end
      ST_MAX: begin
        dividend_o = clk_w;
        divisor_o  = N'(MAX_RATIO);
      end
      ST_D16, ST_D63: begin
        dividend_o = clk_w + (prod >> 1);
        divisor_o  = prod;
      end
      default: begin
        dividend_o = clk_w;
        divisor_o  = N'(1);
      end
    endcase
  end
endmodule

// File: rtl/baud_result_pack.sv
// Clamp prescaler and pack the oversampling fields.
module baud_result_pack #(
  parameter int N      = 48,
  parameter int D_W    = 10,
  parameter int M_MAX  = 63,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [N-1:0]            quot_i,
  input  logic                    use_max_i,
  input  logic                    zero_baud_i,
  output logic [D_W-1:0]          d_o,
  output logic [LANES*LANE_W-1:0] osamp_o,
  output logic                    err_o
);
  localparam logic [N-1:0] D_LIM = N'((1 << D_W) - 1);

  logic m_on;

  always_comb begin
    if (zero_baud_i)          d_o = D_W'(1);
    else if (quot_i == '0)    d_o = D_W'(1);
    else if (quot_i > D_LIM)  d_o = D_LIM[D_W-1:0];
    else                      d_o = quot_i[D_W-1:0];
  end

  assign m_on  = use_max_i && !zero_baud_i;
  assign err_o = zero_baud_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign osamp_o[l*LANE_W +: LANE_W] = m_on ? LANE_W'(M_MAX) : '0;
  end
endmodule

// File: rtl/baud_div_sel.sv
module baud_div_sel
  import baud_div_sel_pkg::*;
#(
  parameter int CLK_W     = 32,
  parameter int D_W       = 10,
  parameter int M_DEF     = 16,
  parameter int M_MAX     = 63,
  parameter int MAX_RATIO = 80,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CLK_W-1:0]        clk_rate_i,
  input  logic [CLK_W-1:0]        baud_i,
  output logic [D_W-1:0]          div_d_o,
  output logic [LANES*LANE_W-1:0] osamp_o,
  output logic                    err_o,
  output logic [CLK_W-1:0]        min_baud_o,
  output logic [CLK_W-1:0]        max_baud_o,
  output logic                    done_o
);
  localparam int D_MAX = (1 << D_W) - 1;
  localparam int N     = CLK_W + 16;

  sel_state_e       state_q;
  logic             issued_q;
  logic [CLK_W-1:0] clk_q, baud_q;
  logic [N-1:0]     quot_q;
  logic             use_max_q;
  logic [CLK_W-1:0] min_q, max_q;

  logic             div_start, div_done;
  logic [N-1:0]     op_dividend, op_divisor, div_quot;
  logic [D_W-1:0]   pk_d;
  logic [LANES*LANE_W-1:0] pk_osamp;
  logic             pk_err, zero_baud, in_op;

  assign zero_baud = (baud_q == '0);
  assign in_op     = (state_q == ST_MIN) || (state_q == ST_MAX) ||
                     (state_q == ST_D16) || (state_q == ST_D63);
  assign div_start = in_op && !issued_q;

  baud_op_mux #(
    .CLK_W(CLK_W), .N(N), .D_MAX(D_MAX), .M_DEF(M_DEF),
    .M_MAX(M_MAX), .MAX_RATIO(MAX_RATIO)
  ) u_mux (
    .state_i   (state_q),
    .clk_rate_i(clk_q),
    .baud_i    (baud_q),
    .dividend_o(op_dividend),
    .divisor_o (op_divisor)
  );

  baud_div_seq #(.N(N)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (div_start),
    .dividend_i(op_dividend),
    .divisor_i (op_divisor),
    .done_o    (div_done),
    .quot_o    (div_quot)
  );

  baud_result_pack #(
    .N(N), .D_W(D_W), .M_MAX(M_MAX), .LANES(LANES), .LANE_W(LANE_W)
  ) u_pack (
    .quot_i     (quot_q),
    .use_max_i  (use_max_q),
    .zero_baud_i(zero_baud),
    .d_o        (pk_d),
    .osamp_o    (pk_osamp),
    .err_o      (pk_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      issued_q   <= 1'b0;
      clk_q      <= '0;
      baud_q     <= '0;
      quot_q     <= '0;
      use_max_q  <= 1'b0;
      min_q      <= '0;
      max_q      <= '0;
      div_d_o    <= D_W'(1);
      osamp_o    <= '0;
      err_o      <= 1'b0;
      min_baud_o <= '0;
      max_baud_o <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (div_start) issued_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          clk_q     <= clk_rate_i;
          baud_q    <= baud_i;
          use_max_q <= 1'b0;
          quot_q    <= '0;
          state_q   <= ST_MIN;
        end
        ST_MIN: if (div_done) begin
          min_q    <= div_quot[CLK_W-1:0];
          issued_q <= 1'b0;
          state_q  <= ST_MAX;
        end
        ST_MAX: if (div_done) begin
          max_q    <= div_quot[CLK_W-1:0];
          issued_q <= 1'b0;
          state_q  <= zero_baud ? ST_FIN : ST_D16;
        end
        ST_D16: if (div_done) begin
          quot_q   <= div_quot;
          issued_q <= 1'b0;
          if (div_quot > N'(D_MAX)) state_q <= ST_D63;
          else                      state_q <= ST_FIN;
        end
        ST_D63: if (div_done) begin
          quot_q    <= div_quot;
          use_max_q <= 1'b1;
          issued_q  <= 1'b0;
          state_q   <= ST_FIN;
        end
        ST_FIN: begin
          div_d_o    <= pk_d;
          osamp_o    <= pk_osamp;
          err_o      <= pk_err;
          min_baud_o <= min_q;
          max_baud_o <= max_q;
          done_o     <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/baud_div_sel_chk.sv
module baud_div_sel_chk #(
  parameter int D_W = 10,
  parameter int OW  = 32,
  parameter int CW  = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          err_o,
  input logic [D_W-1:0] div_d_o,
  input logic [OW-1:0]  osamp_o,
  input logic [CW-1:0]  min_baud_o,
  input logic [CW-1:0]  max_baud_o
);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_d_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (div_d_o != '0));

  a_r4_osamp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (osamp_o == '0 || osamp_o == 32'h3F3F3F3F));

  a_r7_zero_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (div_d_o == D_W'(1) && osamp_o == '0));

  a_r8_hold_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(div_d_o) && $stable(osamp_o) && $stable(err_o)));

  a_r8_hold_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(min_baud_o) && $stable(max_baud_o)));
endmodule

bind baud_div_sel baud_div_sel_chk #(.D_W(D_W), .OW(LANES*LANE_W), .CW(CLK_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_o    (done_o),
  .err_o     (err_o),
  .div_d_o   (div_d_o),
  .osamp_o   (osamp_o),
  .min_baud_o(min_baud_o),
  .max_baud_o(max_baud_o)
);

// File: tb/baud_div_sel_tb_top.sv
module baud_div_sel_tb_top;
  localparam int NV = 10;
  localparam logic [31:0] V_CLK  [NV] = '{32'd25000000, 32'd25000000, 32'd25000000,
    32'd25000000, 32'd1000, 32'd16368, 32'd16384, 32'd24, 32'd23, 32'hFFFFFFFF};
  localparam logic [31:0] V_BAUD [NV] = '{32'd115200, 32'd1200, 32'd100, 32'd0,
    32'd1000, 32'd1, 32'd1, 32'd1, 32'd1, 32'd9600};
  localparam logic [9:0]  V_D    [NV] = '{10'd14, 10'd331, 10'd1023, 10'd1, 10'd1,
    10'd1023, 10'd260, 10'd2, 10'd1, 10'd1023};
  localparam logic        V_M63  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0,
    1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic        V_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] clk_rate = '0, baud = '0;
  logic [9:0]  div_d;
  logic [31:0] osamp, min_baud, max_baud;
  logic        err, done;
  int          total = 0, fails = 0;

  always #2ns clk = ~clk;

  baud_div_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clk_rate_i(clk_rate),
    .baud_i(baud), .div_d_o(div_d), .osamp_o(osamp), .err_o(err),
    .min_baud_o(min_baud), .max_baud_o(max_baud), .done_o(done)
  );

  function automatic string vec_tag(int i);
    case (i)
      0: return "R3";
      1, 6: return "R4";
      2, 4, 9: return "R5";
      3: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(logic [31:0] c, logic [31:0] b);
    @(negedge clk);
    clk_rate = c;
    baud = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done) check("R8 timeout", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 d", div_d, 1);
    check("R1 osamp", osamp, 0);
    check("R1 err", err, 0);
    check("R1 min", min_baud, 0);
    check("R1 max", max_baud, 0);
    check("R1 done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] c64;
      c64 = 64'(V_CLK[i]);
      pulse_start(V_CLK[i], V_BAUD[i]);
      wait_done();
      check({vec_tag(i), " d"}, div_d, V_D[i]);
      check("R4 osamp", osamp, V_M63[i] ? 32'h3F3F3F3F : 32'h0);
      check("R7 err", err, V_ERR[i]);
      check("R6 min", min_baud, (c64 + 64'd64448) / 64'd64449);
      check("R6 max", max_baud, c64 / 64'd80);
      @(negedge clk);
      check("R8 pulse", done, 0);
    end

    // R8: inputs change without start, outputs hold
    clk_rate = 32'd5;
    baud = 32'd0;
    repeat (40) @(negedge clk);
    check("R8 hold d", div_d, 10'd1023);
    check("R8 hold osamp", osamp, 32'h3F3F3F3F);
    check("R8 hold max", max_baud, 32'd53687091);

    // R9: start while busy is dropped
    begin
      int dones = 0;
      pulse_start(32'd25000000, 32'd115200);
      repeat (5) @(negedge clk);
      pulse_start(32'd1000, 32'd1000);
      clk_rate = 32'd7;
      baud = 32'd0;
      wait_done();
      check("R9 d", div_d, 14);
      check("R9 max", max_baud, 312500);
      check("R9 err", err, 0);
      for (int k = 0; k < 600; k++) begin
        @(negedge clk);
        if (done) dones++;
      end
      check("R9 extra done", dones, 0);
      check("R9 d held", div_d, 14);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule